// File: doc/BRIEF.md
# Cache Tag Store with Hit Compare

This block holds one tag word and three status flags for every line of a direct-mapped cache. The stored tag and status of the addressed entry can be read at any time without waiting for a clock. At the same time the stored tag is compared against a probe tag to produce a hit flag. Writes happen on the rising clock edge. The tag field and the status field each have their own active-low write enable, so a controller can update them separately.

A mode input sets the meaning of the status flags. In dedicated mode, bit 0 is a valid flag, bit 1 is a dirty flag and bit 2 is a write-through flag, and the hit flag requires the valid flag. In generic mode, the three flags are plain user bits and the hit flag depends on tag equality only.

A synchronous clear input wipes every status flag in the array in a single clock. Two chip selects of opposite polarity and a power input decide whether the block responds at all. Each output that would be three-state on a board is modelled as a data value plus an enable flag.

Top module: `tag_store_top`

## Requirements
- R1: A tag written at a clock edge (tag_we_n low, block selected) is returned on tag_out for that address, without a clock, whenever tag_oe_n is low, the block is selected, no tag write is in progress and rst is low.
- R2: The status bits are read the same way on stat_out whenever stat_oe_n is low. A tag write leaves the status of the entry unchanged, and a status write leaves the tag of the entry unchanged.
- R3: The block is selected only when sel_lo_n is 0, sel_hi is 1 and pwr_on is 1. Otherwise tag_out_en, stat_out_en and hit_en are all 0. When the block is selected, hit_en is 1.
- R4: In dedicated mode (generic_mode = 0), hit is 1 only when the stored tag equals tag_in and status bit 0 (valid) of the entry is 1.
- R5: In generic mode (generic_mode = 1), hit is 1 exactly when the stored tag equals tag_in, whatever the status bits hold.
- R6: hit is 0 while tag_we_n is low, while stat_we_n is low, and while tag_oe_n is low.
- R7: While stat_we_n and stat_oe_n are both low and the block is selected, stat_out shows stat_in.
- R8: rst high at a rising edge clears all three status bits of every entry in that one edge. While rst is high, stat_out and hit read 0 and tag_out_en is 0.
- R9: rst high together with a low tag_we_n or a low stat_we_n at an edge is illegal. err is then 1 for exactly the following cycle, and the write is discarded.
- R10: When the block is not selected (including when pwr_on is 0), both write enables have no effect on the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes and the clear use its rising edge |
| rst | input | 1 | Synchronous active-high clear of all status bits |
| sel_lo_n | input | 1 | Active-low chip select |
| sel_hi | input | 1 | Active-high chip select |
| pwr_on | input | 1 | 0 puts the block into power-down |
| addr | input | ADDR_W | Entry index |
| tag_in | input | TAG_W | Write data for the tag field and probe tag for the compare |
| stat_in | input | 3 | Status write data (bit 0 valid, bit 1 dirty, bit 2 write-through) |
| tag_we_n | input | 1 | Active-low tag write enable |
| stat_we_n | input | 1 | Active-low status write enable |
| tag_oe_n | input | 1 | Active-low tag read enable |
| stat_oe_n | input | 1 | Active-low status read enable |
| generic_mode | input | 1 | 1 = status bits are user bits, 0 = dedicated flags |
| tag_out | output | TAG_W | Stored tag of the addressed entry |
| tag_out_en | output | 1 | tag_out is being driven |
| stat_out | output | 3 | Status of the addressed entry, or the write data during a write |
| stat_out_en | output | 1 | stat_out is being driven |
| hit | output | 1 | Tag compare result |
| hit_en | output | 1 | hit is being driven |
| err | output | 1 | One-cycle pulse after an illegal clear-plus-write |

## Verification
The bench writes a distinct tag and status to every entry. It then probes each entry with both a matching tag and a tag that differs in one bit, in both modes. A design that ignored the valid flag in dedicated mode, or applied it in generic mode, would report hits on the wrong half of the entries. The bench also drives writes and tag reads while a matching tag is presented, which catches a hit flag that is not held low during those operations. It checks that the status write data appears on stat_out during the write. The clear is raised together with a tag write. A design that let the write through, cleared only the addressed entry, or missed the one-cycle error pulse would show a changed tag, leftover status bits or a wrong err value. Finally, the bench tries all eight combinations of the two chip selects and the power input, and writes while deselected, to expose any leaking output enable or write.

// File: rtl/tag_store_pkg.sv
package tag_store_pkg;

    localparam int STAT_W = 3;

    // Bit 0 is the valid flag; the hit qualifier depends on that position.
    typedef struct packed {
        logic wthru;
        logic dirty;
        logic valid;
    } stat_t;

    typedef struct packed {
        logic active;     // both selects asserted and powered
        logic clear;      // flash clear of status bank
        logic tag_wr;     // tag write committed at this edge
        logic stat_wr;    // status write committed at this edge
        logic tag_rd;     // tag output driven
        logic stat_rd;    // status output driven
        logic hit_block;  // hit forced low
        logic bad_combo;  // clear together with a write
    } ctrl_t;

    function automatic logic qualify_hit(input logic equal, input stat_t st,
                                         input logic generic);
        return equal && (generic || st.valid);
    endfunction

endpackage

// File: rtl/tag_ctrl.sv
module tag_ctrl
    import tag_store_pkg::*;
(
    input  logic  rst,
    input  logic  sel_lo_n,
    input  logic  sel_hi,
    input  logic  pwr_on,
    input  logic  tag_we_n,
    input  logic  stat_we_n,
    input  logic  tag_oe_n,
    input  logic  stat_oe_n,
    output ctrl_t ctl
);

    logic any_wr;

    always_comb begin
        any_wr        = !tag_we_n || !stat_we_n;
        ctl.active    = !sel_lo_n && sel_hi && pwr_on;
        ctl.clear     = rst;
        ctl.bad_combo = rst && any_wr;
        // Clear wins over any write request.
        ctl.tag_wr    = ctl.active && !tag_we_n && !rst;
        ctl.stat_wr   = ctl.active && !stat_we_n && !rst;
        ctl.tag_rd    = ctl.active && !tag_oe_n && tag_we_n && !rst;
        ctl.stat_rd   = ctl.active && !stat_oe_n;
        ctl.hit_block = any_wr || !tag_oe_n || rst;
    end

endmodule

// File: rtl/tag_mem.sv
module tag_mem #(
    parameter int ADDR_W = 6,
    parameter int TAG_W  = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TAG_W-1:0]  wdata,
    output logic [TAG_W-1:0]  rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [TAG_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/stat_bank.sv
module stat_bank
    import tag_store_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  stat_t             wdata,
    output stat_t             rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    stat_t            bank [DEPTH];
    logic [DEPTH-1:0] wsel;

    for (genvar i = 0; i < DEPTH; i++) begin : g_dec
        assign wsel[i] = we && (addr == ADDR_W'(i));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (clr)          bank[i] <= '0;
            else if (wsel[i]) bank[i] <= wdata;
        end
    end

    assign rdata = bank[addr];

endmodule

// File: rtl/tag_cmp.sv
module tag_cmp
    import tag_store_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic [TAG_W-1:0] stored,
    input  logic [TAG_W-1:0] probe,
    input  stat_t            st,
    input  logic             generic,
    input  logic             block,
    output logic             hit_raw
);

    always_comb hit_raw = !block && qualify_hit(stored == probe, st, generic);

endmodule

// File: rtl/tag_store_top.sv
module tag_store_top
    import tag_store_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int TAG_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_lo_n,
    input  logic              sel_hi,
    input  logic              pwr_on,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic [2:0]        stat_in,
    input  logic              tag_we_n,
    input  logic              stat_we_n,
    input  logic              tag_oe_n,
    input  logic              stat_oe_n,
    input  logic              generic_mode,
    output logic [TAG_W-1:0]  tag_out,
    output logic              tag_out_en,
    output logic [2:0]        stat_out,
    output logic              stat_out_en,
    output logic              hit,
    output logic              hit_en,
    output logic              err
);

    ctrl_t            ctl;
    logic [TAG_W-1:0] rd_tag;
    stat_t            rd_stat;
    stat_t            wr_stat;
    logic             hit_raw;
    logic             err_q;

    assign wr_stat = stat_t'(stat_in);

    tag_ctrl u_ctrl (
        .rst       (rst),
        .sel_lo_n  (sel_lo_n),
        .sel_hi    (sel_hi),
        .pwr_on    (pwr_on),
        .tag_we_n  (tag_we_n),
        .stat_we_n (stat_we_n),
        .tag_oe_n  (tag_oe_n),
        .stat_oe_n (stat_oe_n),
        .ctl       (ctl)
    );

    tag_mem #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_tags (
        .clk   (clk),
        .we    (ctl.tag_wr),
        .addr  (addr),
        .wdata (tag_in),
        .rdata (rd_tag)
    );

    stat_bank #(.ADDR_W(ADDR_W)) u_stat (
        .clk   (clk),
        .clr   (ctl.clear),
        .we    (ctl.stat_wr),
        .addr  (addr),
        .wdata (wr_stat),
        .rdata (rd_stat)
    );

    tag_cmp #(.TAG_W(TAG_W)) u_cmp (
        .stored  (rd_tag),
        .probe   (tag_in),
        .st      (rd_stat),
        .generic (generic_mode),
        .block   (ctl.hit_block),
        .hit_raw (hit_raw)
    );

    // Illegal clear-plus-write pulse, recomputed every edge.
    always_ff @(posedge clk) begin
        err_q <= ctl.bad_combo;
    end

    always_comb begin
        tag_out_en  = ctl.tag_rd;
        tag_out     = ctl.tag_rd ? rd_tag : '0;
        stat_out_en = ctl.stat_rd;
        if (!ctl.stat_rd || ctl.clear) stat_out = '0;
        else if (ctl.stat_wr)          stat_out = stat_in;
        else                           stat_out = rd_stat;
        hit_en      = ctl.active;
        hit         = ctl.active && hit_raw;
        err         = err_q;
    end

endmodule

// File: rtl/tag_store_chk.sv
module tag_store_chk #(
    parameter int TAG_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             sel_lo_n,
    input logic             sel_hi,
    input logic             pwr_on,
    input logic             tag_we_n,
    input logic             stat_we_n,
    input logic             tag_oe_n,
    input logic             generic_mode,
    input logic [TAG_W-1:0] tag_in,
    input logic [2:0]       stat_in,
    input logic             tag_out_en,
    input logic [2:0]       stat_out,
    input logic             stat_out_en,
    input logic             hit,
    input logic             hit_en,
    input logic             err,
    input logic [TAG_W-1:0] rd_tag,
    input logic [2:0]       rd_stat
);

    assert_deselect_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (sel_lo_n || !sel_hi || !pwr_on) |-> !(tag_out_en || stat_out_en || hit_en));

    assert_valid_gates_hit_R4: assert property (@(posedge clk) disable iff (rst)
        (hit && !generic_mode) |-> rd_stat[0]);

    assert_hit_needs_equal_R5: assert property (@(posedge clk) disable iff (rst)
        hit |-> (rd_tag == tag_in));

    assert_busy_no_hit_R6: assert property (@(posedge clk) disable iff (rst)
        (!tag_we_n || !stat_we_n || !tag_oe_n) |-> !hit);

    assert_status_passthru_R7: assert property (@(posedge clk) disable iff (rst)
        (stat_out_en && !stat_we_n) |-> (stat_out == stat_in));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && stat_we_n) |-> (stat_out == 3'b000));

    assert_err_cause_R9: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(rst && (!tag_we_n || !stat_we_n)));

endmodule

bind tag_store_top tag_store_chk #(.TAG_W(TAG_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sel_lo_n     (sel_lo_n),
    .sel_hi       (sel_hi),
    .pwr_on       (pwr_on),
    .tag_we_n     (tag_we_n),
    .stat_we_n    (stat_we_n),
    .tag_oe_n     (tag_oe_n),
    .generic_mode (generic_mode),
    .tag_in       (tag_in),
    .stat_in      (stat_in),
    .tag_out_en   (tag_out_en),
    .stat_out     (stat_out),
    .stat_out_en  (stat_out_en),
    .hit          (hit),
    .hit_en       (hit_en),
    .err          (err),
    .rd_tag       (rd_tag),
    .rd_stat      (rd_stat)
);

// File: tb/tag_store_top_test.sv
`timescale 1ns/1ps
module tag_store_top_test;

    localparam int AW = 6;
    localparam int TW = 12;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel_lo_n = 1'b0, sel_hi = 1'b1, pwr_on = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [TW-1:0] tag_in = '0;
    logic [2:0]    stat_in = '0;
    logic          tag_we_n = 1'b1, stat_we_n = 1'b1;
    logic          tag_oe_n = 1'b1, stat_oe_n = 1'b1;
    logic          generic_mode = 1'b0;
    logic [TW-1:0] tag_out;
    logic          tag_out_en;
    logic [2:0]    stat_out;
    logic          stat_out_en, hit, hit_en, err;

    int total = 0;
    int bad   = 0;

    logic [TW-1:0] exp_tag  [N];
    logic [2:0]    exp_stat [N];

    tag_store_top #(.ADDR_W(AW), .TAG_W(TW)) uut (
        .clk(clk), .rst(rst), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi), .pwr_on(pwr_on),
        .addr(addr), .tag_in(tag_in), .stat_in(stat_in),
        .tag_we_n(tag_we_n), .stat_we_n(stat_we_n),
        .tag_oe_n(tag_oe_n), .stat_oe_n(stat_oe_n), .generic_mode(generic_mode),
        .tag_out(tag_out), .tag_out_en(tag_out_en), .stat_out(stat_out),
        .stat_out_en(stat_out_en), .hit(hit), .hit_en(hit_en), .err(err)
    );

    always #2.5 clk = ~clk;

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [TW-1:0] tag_of(input int a, input int salt);
        return TW'((a * 37 + 5 + salt * 911) % 4096);
    endfunction

    task automatic put_tag(input int a, input logic [TW-1:0] t);
        addr = AW'(a); tag_in = t; tag_we_n = 1'b0;
        #1 check("R6 hit during tag write", hit, 0);
        step();
        tag_we_n = 1'b1;
        exp_tag[a] = t;
    endtask

    task automatic put_stat(input int a, input logic [2:0] s);
        addr = AW'(a); stat_in = s; stat_we_n = 1'b0; stat_oe_n = 1'b0;
        tag_in = exp_tag[a];
        #1 check("R7 status pass-through", stat_out, s);
        check("R6 hit during status write", hit, 0);
        step();
        stat_we_n = 1'b1; stat_oe_n = 1'b1;
        exp_stat[a] = s;
    endtask

    task automatic read_all(input bit with_tag);
        for (int a = 0; a < N; a++) begin
            addr = AW'(a); tag_oe_n = with_tag ? 1'b0 : 1'b1; stat_oe_n = 1'b0;
            tag_in = exp_tag[a];
            #1;
            if (with_tag) begin
                check("R1 tag readback", tag_out, exp_tag[a]);
                check("R6 hit during tag read", hit, 0);
            end
            check("R2 status readback", stat_out, exp_stat[a]);
        end
        tag_oe_n = 1'b1; stat_oe_n = 1'b1;
        #1;
    endtask

    task automatic probe_all();
        for (int m = 0; m < 2; m++) begin
            generic_mode = m[0];
            for (int a = 0; a < N; a++) begin
                addr = AW'(a); tag_in = exp_tag[a];
                #1;
                if (m == 0) check("R4 dedicated hit", hit, exp_stat[a][0]);
                else        check("R5 generic hit", hit, 1);
                tag_in = exp_tag[a] ^ TW'(1 << (a % TW));
                #1;
                if (m == 0) check("R4 dedicated miss", hit, 0);
                else        check("R5 generic miss", hit, 0);
            end
        end
        generic_mode = 1'b0;
    endtask

    initial begin
        // reset state
        step(); step();
        rst = 1'b0;
        for (int a = 0; a < N; a++) exp_stat[a] = 3'b000;
        check("R9 err idle", err, 0);
        check("R3 hit_en selected", hit_en, 1);
        read_all(0);

        // fill every entry
        for (int a = 0; a < N; a++) put_tag(a, tag_of(a, 0));
        for (int a = 0; a < N; a++) put_stat(a, 3'(a % 8));
        read_all(1);
        probe_all();

        // field independence
        put_tag(3, tag_of(3, 1));
        put_stat(5, 3'b110);
        read_all(1);

        // select / power combinations
        for (int c = 0; c < 8; c++) begin
            sel_lo_n = c[0]; sel_hi = c[1]; pwr_on = c[2];
            addr = 6'd1; tag_oe_n = 1'b0; stat_oe_n = 1'b0;
            #1;
            check("R3 tag_out_en", tag_out_en, c == 6);
            check("R3 stat_out_en", stat_out_en, c == 6);
            check("R3 hit_en", hit_en, c == 6);
        end
        tag_oe_n = 1'b1; stat_oe_n = 1'b1;

        // writes while not selected
        for (int c = 0; c < 3; c++) begin
            sel_lo_n = (c == 0); sel_hi = (c != 1); pwr_on = (c != 2);
            addr = AW'(7 + c); tag_in = ~exp_tag[7 + c]; stat_in = ~exp_stat[7 + c];
            tag_we_n = 1'b0; stat_we_n = 1'b0;
            step();
            tag_we_n = 1'b1; stat_we_n = 1'b1;
        end
        sel_lo_n = 1'b0; sel_hi = 1'b1; pwr_on = 1'b1;
        for (int a = 7; a < 10; a++) begin
            addr = AW'(a); tag_oe_n = 1'b0; stat_oe_n = 1'b0;
            #1;
            check("R10 tag kept while unselected", tag_out, exp_tag[a]);
            check("R10 status kept while unselected", stat_out, exp_stat[a]);
        end
        tag_oe_n = 1'b1; stat_oe_n = 1'b1;

        // illegal clear plus tag write
        addr = 6'd9; tag_in = exp_tag[9]; stat_oe_n = 1'b0;
        #1 check("R4 pre-clear hit", hit, exp_stat[9][0]);
        rst = 1'b1; tag_we_n = 1'b0; tag_in = ~exp_tag[9];
        #1;
        check("R8 status low during clear", stat_out, 0);
        check("R8 hit low during clear", hit, 0);
        check("R8 tag output off during clear", tag_out_en, 0);
        step();
        rst = 1'b0; tag_we_n = 1'b1; stat_oe_n = 1'b1;
        for (int a = 0; a < N; a++) exp_stat[a] = 3'b000;
        #1 check("R9 err pulse", err, 1);
        step();
        check("R9 err single cycle", err, 0);
        read_all(1);
        probe_all();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule